// File: doc/BRIEF.md
# Dual Accumulator Saturation Unit

This block keeps two 40-bit signed fractional accumulators (eight guard bits above a 1.31 fraction) and decides what each adder result turns into before it is stored. A one-bit target select picks accumulator A or B. A two-bit mode picks one of three overflow policies:
- clamp the result at the full 40-bit limits;
- clamp it at the 1.31 limits;
- store the wrapped sum and only record the overflow.

Each accumulator has a guard-spill flag and a sticky saturation flag. OR-combined copies of both are also output. In the wrapping policy an adder overflow can raise a trap request when traps are enabled.

All state is registered. A write presented in one cycle shows up on the accumulator, flag and trap outputs after the next rising clock edge. The combined flags follow the registered per-accumulator flags with no added delay. Software clears the sticky saturation flags with one strobe per accumulator.

Top module: `dacc_sat_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, both accumulators, all four per-accumulator flags, both combined flags and the trap request are zero.
- R2: In mode 2'b00 (clamp at 40 bits), a write with the adder overflow high stores 0x7FFFFFFFFF when the true sum is positive and 0x8000000000 when it is negative. The target's saturation flag is then set.
- R3: A write that is not clamped stores the 40-bit adder result unchanged. After any write, the target's guard flag is 1 exactly when bits 39 down to 31 of the stored value are not all equal.
- R4: In mode 2'b01 (clamp at 1.31), a result whose true value is above 0x7FFFFFFF stores 0x007FFFFFFF, and one below -2^31 stores 0xFF80000000. This also applies when the adder overflowed. In both cases the target's saturation flag is set.
- R5: After any write in mode 2'b01, the target's guard flag is 0.
- R6: In modes 2'b10 and 2'b11 (wrap), the adder result is stored unclamped. The adder overflow alone sets the target's saturation flag.
- R7: The trap request is high for the cycle after a write in a wrap mode that has both the adder overflow and the trap enable high. It is low in every other cycle.
- R8: A saturation flag stays set until its clear strobe is high. A clear strobe wins over a set of the same flag in the same cycle.
- R9: The combined guard flag is OA OR OB, and the combined saturation flag is SA OR SB.
- R10: Target select 0 writes A and 1 writes B. The accumulator that is not targeted, and both accumulators when write enable is low, keep their value and guard flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | A write this cycle |
| tgt_sel_i | input | 1 | Target accumulator: 0 = A, 1 = B |
| mode_i | input | 2 | Overflow policy: 00 clamp-40, 01 clamp-1.31, 10/11 wrap |
| sum_i | input | ACC_W | Adder result, two's complement |
| sum_ovf_i | input | 1 | Adder signed overflow out of bit ACC_W-1 |
| trap_en_i | input | 1 | Enables the trap request in wrap mode |
| clr_sat_a_i | input | 1 | Clears the A saturation flag |
| clr_sat_b_i | input | 1 | Clears the B saturation flag |
| acc_a_o | output | ACC_W | Accumulator A |
| acc_b_o | output | ACC_W | Accumulator B |
| ovf_a_o | output | 1 | A guard-spill flag |
| ovf_b_o | output | 1 | B guard-spill flag |
| ovf_any_o | output | 1 | OR of the guard flags |
| sat_a_o | output | 1 | A sticky saturation flag |
| sat_b_o | output | 1 | B sticky saturation flag |
| sat_any_o | output | 1 | OR of the saturation flags |
| trap_o | output | 1 | Trap request, one cycle |

## Verification
The bench uses the default widths, ACC_W = 40 and NAR_W = 32. This keeps the true sum within a 41-bit signed value that the bench forms itself from two operands. The bench steers its operands toward plus and minus 2^39 and plus and minus 2^31. Random traffic therefore reaches adder overflow and 1.31 clamping often, not only in rare cases. It also reaches sums that spill into the guard bits without overflowing.

// File: rtl/dacc_pkg.sv
package dacc_pkg;

  typedef enum logic [1:0] {
    OVM_CLAMP_WIDE   = 2'b00,
    OVM_CLAMP_NARROW = 2'b01,
    OVM_WRAP         = 2'b10,
    OVM_WRAP_ALT     = 2'b11
  } ovf_mode_e;

  typedef struct packed {
    logic clamp;     // result was replaced by a limit
    logic wrap_ovf;  // overflow recorded without clamping
    logic flag_set;  // saturation flag of the target must be set
    logic spill;     // stored value reaches into the guard bits
  } path_evt_t;

endpackage

// File: rtl/dacc_sat_path.sv
module dacc_sat_path
  import dacc_pkg::*;
#(
  parameter int ACC_W = 40,
  parameter int NAR_W = 32
) (
  input  logic [ACC_W-1:0] sum_i,
  input  logic             sum_ovf_i,
  input  ovf_mode_e        mode_i,
  output logic [ACC_W-1:0] res_o,
  output path_evt_t        evt_o
);

  localparam int TOP_W = ACC_W - NAR_W + 1;

  function automatic logic spills(input logic [ACC_W-1:0] v);
    logic [TOP_W-1:0] t;
    t = v[ACC_W-1:NAR_W-1];
    return !((&t) | (~|t));
  endfunction

  function automatic logic [ACC_W-1:0] wide_limit(input logic neg);
    return neg ? {1'b1, {(ACC_W-1){1'b0}}} : {1'b0, {(ACC_W-1){1'b1}}};
  endfunction

  function automatic logic [ACC_W-1:0] narrow_limit(input logic neg);
    return neg ? {{TOP_W{1'b1}}, {(NAR_W-1){1'b0}}}
               : {{TOP_W{1'b0}}, {(NAR_W-1){1'b1}}};
  endfunction

  logic true_neg;
  logic clamp;
  logic wrap_ovf;

  // with an adder overflow the stored sign is the inverse of the true sign
  assign true_neg = sum_ovf_i ? ~sum_i[ACC_W-1] : sum_i[ACC_W-1];

  always_comb begin
    res_o    = sum_i;
    clamp    = 1'b0;
    wrap_ovf = 1'b0;
    unique case (mode_i)
      OVM_CLAMP_WIDE: begin
        if (sum_ovf_i) begin
          res_o = wide_limit(true_neg);
          clamp = 1'b1;
        end
      end
      OVM_CLAMP_NARROW: begin
        if (sum_ovf_i || spills(sum_i)) begin
          res_o = narrow_limit(true_neg);
          clamp = 1'b1;
        end
      end
      default: begin
        wrap_ovf = sum_ovf_i;
      end
    endcase
  end

  assign evt_o.clamp    = clamp;
  assign evt_o.wrap_ovf = wrap_ovf;
  assign evt_o.flag_set = clamp | wrap_ovf;
  assign evt_o.spill    = spills(res_o);

endmodule

// File: rtl/dacc_acc_slot.sv
module dacc_acc_slot #(
  parameter int ACC_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [ACC_W-1:0] res_i,
  input  logic             spill_i,
  input  logic             flag_set_i,
  input  logic             clr_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             ovf_o,
  output logic             sat_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_o <= '0;
      ovf_o <= 1'b0;
    end else if (wr_i) begin
      acc_o <= res_i;
      ovf_o <= spill_i;
    end
  end

  // sticky flag, the clear strobe takes precedence
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sat_o <= 1'b0;
    end else if (clr_i) begin
      sat_o <= 1'b0;
    end else if (wr_i && flag_set_i) begin
      sat_o <= 1'b1;
    end
  end

endmodule

// File: rtl/dacc_trap_gen.sv
module dacc_trap_gen
  import dacc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_i,
  input  path_evt_t evt_i,
  input  logic      trap_en_i,
  output logic      trap_o
);

  logic trap_evt;
  assign trap_evt = wr_i && evt_i.wrap_ovf && trap_en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trap_o <= 1'b0;
    else        trap_o <= trap_evt;
  end

endmodule

// File: rtl/dacc_sat_unit.sv
module dacc_sat_unit
  import dacc_pkg::*;
#(
  parameter int ACC_W = 40,
  parameter int NAR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic             tgt_sel_i,
  input  logic [1:0]       mode_i,
  input  logic [ACC_W-1:0] sum_i,
  input  logic             sum_ovf_i,
  input  logic             trap_en_i,
  input  logic             clr_sat_a_i,
  input  logic             clr_sat_b_i,
  output logic [ACC_W-1:0] acc_a_o,
  output logic [ACC_W-1:0] acc_b_o,
  output logic             ovf_a_o,
  output logic             ovf_b_o,
  output logic             ovf_any_o,
  output logic             sat_a_o,
  output logic             sat_b_o,
  output logic             sat_any_o,
  output logic             trap_o
);

  localparam int NUM_ACC = 2;

  logic [ACC_W-1:0] path_res;
  path_evt_t        path_evt;
  logic             path_flag_set;

  logic [ACC_W-1:0] acc_q   [NUM_ACC];
  logic             ovf_q   [NUM_ACC];
  logic             sat_q   [NUM_ACC];
  logic             clr_vec [NUM_ACC];
  logic             wr_vec  [NUM_ACC];

  dacc_sat_path #(.ACC_W(ACC_W), .NAR_W(NAR_W)) u_path (
    .sum_i     (sum_i),
    .sum_ovf_i (sum_ovf_i),
    .mode_i    (ovf_mode_e'(mode_i)),
    .res_o     (path_res),
    .evt_o     (path_evt)
  );

  assign path_flag_set = path_evt.flag_set;
  assign clr_vec[0]    = clr_sat_a_i;
  assign clr_vec[1]    = clr_sat_b_i;

  for (genvar s = 0; s < NUM_ACC; s++) begin : g_slot
    assign wr_vec[s] = wr_en_i && (tgt_sel_i == s[0]);
    dacc_acc_slot #(.ACC_W(ACC_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (wr_vec[s]),
      .res_i      (path_res),
      .spill_i    (path_evt.spill),
      .flag_set_i (path_flag_set),
      .clr_i      (clr_vec[s]),
      .acc_o      (acc_q[s]),
      .ovf_o      (ovf_q[s]),
      .sat_o      (sat_q[s])
    );
  end

  dacc_trap_gen u_trap (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (wr_en_i),
    .evt_i     (path_evt),
    .trap_en_i (trap_en_i),
    .trap_o    (trap_o)
  );

  assign acc_a_o   = acc_q[0];
  assign acc_b_o   = acc_q[1];
  assign ovf_a_o   = ovf_q[0];
  assign ovf_b_o   = ovf_q[1];
  assign sat_a_o   = sat_q[0];
  assign sat_b_o   = sat_q[1];
  assign ovf_any_o = ovf_q[0] | ovf_q[1];
  assign sat_any_o = sat_q[0] | sat_q[1];

endmodule

// File: rtl/dacc_sat_unit_chk.sv
module dacc_sat_unit_chk #(
  parameter int ACC_W = 40,
  parameter int NAR_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en_i,
  input logic             tgt_sel_i,
  input logic [1:0]       mode_i,
  input logic [ACC_W-1:0] sum_i,
  input logic             sum_ovf_i,
  input logic             trap_en_i,
  input logic             clr_sat_a_i,
  input logic             clr_sat_b_i,
  input logic [ACC_W-1:0] acc_a_o,
  input logic [ACC_W-1:0] acc_b_o,
  input logic             ovf_a_o,
  input logic             ovf_b_o,
  input logic             sat_a_o,
  input logic             sat_b_o,
  input logic             trap_o,
  input logic             path_flag_set
);

  localparam int TOP_W = ACC_W - NAR_W + 1;
  localparam logic [ACC_W-1:0] WMAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] WMIN = {1'b1, {(ACC_W-1){1'b0}}};

  function automatic logic fits_narrow(input logic [ACC_W-1:0] v);
    return (v[ACC_W-1:NAR_W-1] == {TOP_W{1'b0}}) ||
           (v[ACC_W-1:NAR_W-1] == {TOP_W{1'b1}});
  endfunction

  logic [ACC_W-1:0] tgt_acc;
  assign tgt_acc = tgt_sel_i ? acc_b_o : acc_a_o;

  a_r2_wide_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && mode_i == 2'b00 && sum_ovf_i |=>
      (($past(tgt_sel_i) ? acc_b_o : acc_a_o) ==
       ($past(sum_i[ACC_W-1]) ? WMAX : WMIN)));

  a_r4_narrow_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && mode_i == 2'b01 |=>
      fits_narrow($past(tgt_sel_i) ? acc_b_o : acc_a_o));

  a_r5_no_guard_a: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && mode_i == 2'b01 && !tgt_sel_i |=> !ovf_a_o);

  a_r5_no_guard_b: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && mode_i == 2'b01 && tgt_sel_i |=> !ovf_b_o);

  a_r6_wrap_store: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && mode_i[1] |=>
      (($past(tgt_sel_i) ? acc_b_o : acc_a_o) == $past(sum_i)));

  a_r7_trap_fires: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && mode_i[1] && sum_ovf_i && trap_en_i |=> trap_o);

  a_r7_trap_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && mode_i[1] && sum_ovf_i && trap_en_i) |=> !trap_o);

  a_r8_clear_wins_a: assert property (@(posedge clk) disable iff (!rst_n)
    clr_sat_a_i |=> !sat_a_o);

  a_r8_clear_wins_b: assert property (@(posedge clk) disable iff (!rst_n)
    clr_sat_b_i |=> !sat_b_o);

  a_r8_sticky_a: assert property (@(posedge clk) disable iff (!rst_n)
    sat_a_o && !clr_sat_a_i |=> sat_a_o);

  a_r8_sticky_b: assert property (@(posedge clk) disable iff (!rst_n)
    sat_b_o && !clr_sat_b_i |=> sat_b_o);

  a_r8_set_a: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && !tgt_sel_i && path_flag_set && !clr_sat_a_i |=> sat_a_o);

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(acc_a_o) && $stable(acc_b_o));

  a_r10_other_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> ($past(tgt_sel_i) ? $stable(acc_a_o) : $stable(acc_b_o)));

  a_r3_tgt_seen: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && mode_i[1] && !sum_ovf_i && fits_narrow(sum_i) |=>
      fits_narrow(tgt_acc) || !$stable(tgt_sel_i));

endmodule

bind dacc_sat_unit dacc_sat_unit_chk #(.ACC_W(ACC_W), .NAR_W(NAR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_en_i       (wr_en_i),
  .tgt_sel_i     (tgt_sel_i),
  .mode_i        (mode_i),
  .sum_i         (sum_i),
  .sum_ovf_i     (sum_ovf_i),
  .trap_en_i     (trap_en_i),
  .clr_sat_a_i   (clr_sat_a_i),
  .clr_sat_b_i   (clr_sat_b_i),
  .acc_a_o       (acc_a_o),
  .acc_b_o       (acc_b_o),
  .ovf_a_o       (ovf_a_o),
  .ovf_b_o       (ovf_b_o),
  .sat_a_o       (sat_a_o),
  .sat_b_o       (sat_b_o),
  .trap_o        (trap_o),
  .path_flag_set (path_flag_set)
);

// File: tb/dacc_sat_unit_test.sv
module dacc_sat_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int W = 40;
  localparam logic signed [W:0] MAX31 = 41'sd2147483647;
  localparam logic signed [W:0] MIN31 = -41'sd2147483648;
  localparam logic signed [W:0] MAX39 = 41'sd549755813887;
  localparam logic signed [W:0] MIN39 = -41'sd549755813888;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic         tgt = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic [W-1:0] sum = '0;
  logic         sovf = 1'b0;
  logic         ten = 1'b0;
  logic         clra = 1'b0;
  logic         clrb = 1'b0;
  logic [W-1:0] acc_a, acc_b;
  logic         ovf_a, ovf_b, ovf_any, sat_a, sat_b, sat_any, trap;

  int n_chk = 0;
  int n_bad = 0;

  logic [W-1:0] m_acc [2];
  logic         m_ovf [2];
  logic         m_sat [2];
  logic         m_trap;

  always #(CLK_PERIOD/2) clk = ~clk;

  dacc_sat_unit #(.ACC_W(W), .NAR_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .tgt_sel_i(tgt), .mode_i(mode),
    .sum_i(sum), .sum_ovf_i(sovf), .trap_en_i(ten),
    .clr_sat_a_i(clra), .clr_sat_b_i(clrb),
    .acc_a_o(acc_a), .acc_b_o(acc_b), .ovf_a_o(ovf_a), .ovf_b_o(ovf_b),
    .ovf_any_o(ovf_any), .sat_a_o(sat_a), .sat_b_o(sat_b),
    .sat_any_o(sat_any), .trap_o(trap)
  );

  task automatic chk(input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic out_of_narrow(input logic signed [W:0] v);
    return (v > MAX31) || (v < MIN31);
  endfunction

  task automatic check_all(input string req);
    chk(req, "acc_a", acc_a, m_acc[0]);
    chk(req, "acc_b", acc_b, m_acc[1]);
    chk(req, "ovf_a", W'(ovf_a), W'(m_ovf[0]));
    chk(req, "ovf_b", W'(ovf_b), W'(m_ovf[1]));
    chk(req, "sat_a", W'(sat_a), W'(m_sat[0]));
    chk(req, "sat_b", W'(sat_b), W'(m_sat[1]));
    chk("R9", "ovf_any", W'(ovf_any), W'(m_ovf[0] | m_ovf[1]));
    chk("R9", "sat_any", W'(sat_any), W'(m_sat[0] | m_sat[1]));
    chk(req, "trap", W'(trap), W'(m_trap));
  endtask

  // one cycle: called at a falling edge, checks at the next falling edge
  task automatic cyc(input logic wr, input logic t, input logic [1:0] md,
                     input logic [W-1:0] x, input logic [W-1:0] y,
                     input logic te, input logic ca, input logic cb,
                     input string req);
    logic signed [W:0] tv;
    logic [W-1:0]      res;
    logic              ov, setf;
    tv  = $signed({x[W-1], x}) + $signed({y[W-1], y});
    ov  = tv[W] != tv[W-1];
    wr_en = wr; tgt = t; mode = md; sum = tv[W-1:0]; sovf = ov;
    ten = te; clra = ca; clrb = cb;
    res  = tv[W-1:0];
    setf = 1'b0;
    if (md == 2'b00) begin
      if (tv > MAX39)      begin res = MAX39[W-1:0]; setf = 1'b1; end
      else if (tv < MIN39) begin res = MIN39[W-1:0]; setf = 1'b1; end
    end else if (md == 2'b01) begin
      if (tv > MAX31)      begin res = MAX31[W-1:0]; setf = 1'b1; end
      else if (tv < MIN31) begin res = MIN31[W-1:0]; setf = 1'b1; end
    end else begin
      setf = ov;
    end
    m_trap = wr && md[1] && ov && te;
    if (wr) begin
      m_acc[t] = res;
      m_ovf[t] = out_of_narrow($signed({res[W-1], res}));
      if (setf) m_sat[t] = 1'b1;
    end
    if (ca) m_sat[0] = 1'b0;
    if (cb) m_sat[1] = 1'b0;
    @(negedge clk);
    check_all(req);
  endtask

  function automatic logic [W-1:0] pick_operand();
    logic [63:0] r;
    r = {$urandom, $urandom};
    case ($urandom % 5)
      0: return r[W-1:0];
      1: return {{8{r[31]}}, r[31:0]};
      2: return 40'h7F_FFFF_FF00 - W'(r[11:0]);
      3: return 40'h80_0000_0000 + W'(r[11:0]);
      default: return {{8{r[31]}}, r[31:28], 28'h0} ^ W'(r[15:0]);
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 2; i++) begin
      m_acc[i] = '0; m_ovf[i] = 1'b0; m_sat[i] = 1'b0;
    end
    m_trap = 1'b0;
    repeat (3) @(negedge clk);
    check_all("R1");                       // during reset
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");                       // first cycle out of reset

    // R2: positive and negative overflow clamp at 40 bits
    cyc(1, 0, 2'b00, 40'h7F_0000_0000, 40'h10_0000_0000, 0, 0, 0, "R2");
    cyc(1, 1, 2'b00, 40'h80_0000_0001, 40'hF0_0000_0000, 0, 0, 0, "R2");
    // R3: guard spill without overflow in clamp-40 mode, then back in range
    cyc(1, 0, 2'b00, 40'h00_8000_0000, 40'h00_0000_0001, 0, 1, 0, "R3");
    cyc(1, 0, 2'b00, 40'h00_1234_5678, 40'h00_0000_0001, 0, 0, 0, "R3");
    // R4: clamp at 1.31, positive, negative, and with adder overflow
    cyc(1, 0, 2'b01, 40'h00_7FFF_FFFF, 40'h00_0000_0001, 0, 0, 1, "R4");
    cyc(1, 1, 2'b01, 40'hFF_8000_0000, 40'hFF_FFFF_FFFF, 0, 0, 0, "R4");
    cyc(1, 1, 2'b01, 40'h7F_FFFF_FFFF, 40'h00_0000_0005, 0, 0, 0, "R4");
    // R5: guard flag stays low in 1.31 mode, even for in-range values
    cyc(1, 0, 2'b01, 40'h00_0000_1000, 40'hFF_FFFF_0000, 0, 1, 1, "R5");
    // R6 and R7: wrap mode, trap enabled and disabled, mode 11
    cyc(1, 0, 2'b10, 40'h7F_FFFF_FFFF, 40'h00_0000_0001, 1, 0, 0, "R7");
    cyc(0, 0, 2'b10, 40'h7F_FFFF_FFFF, 40'h00_0000_0001, 1, 0, 0, "R7");
    cyc(1, 1, 2'b11, 40'h80_0000_0000, 40'hFF_FFFF_FFFF, 0, 0, 0, "R6");
    cyc(1, 1, 2'b11, 40'h00_0000_0003, 40'h00_0000_0004, 1, 0, 0, "R6");
    // R8: clear wins over a same-cycle set, then sticky hold
    cyc(1, 0, 2'b00, 40'h7F_0000_0000, 40'h7F_0000_0000, 0, 1, 0, "R8");
    cyc(1, 0, 2'b00, 40'h7F_0000_0000, 40'h7F_0000_0000, 0, 0, 0, "R8");
    cyc(1, 0, 2'b00, 40'h00_0000_0001, 40'h00_0000_0001, 0, 0, 0, "R8");
    // R10: idle cycle with a changing sum, and a write to B only
    cyc(0, 0, 2'b10, 40'h12_3456_789A, 40'h00_0000_0000, 1, 0, 0, "R10");
    cyc(1, 1, 2'b10, 40'h00_0000_00AB, 40'h00_0000_0000, 0, 0, 0, "R10");

    for (int k = 0; k < 3000; k++) begin
      logic [3:0] r;
      r = 4'($urandom);
      cyc(r[3] | r[2] | r[1], 1'($urandom), 2'($urandom),
          pick_operand(), pick_operand(), 1'($urandom),
          ($urandom % 8) == 0, ($urandom % 8) == 0, "R10");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule